// File: doc/BRIEF.md
# Bank-Tracking SDRAM Command Scheduler

This block turns read and write requests from a simple valid/busy user port into SDRAM command sequences. It keeps a table that records, for every bank, whether a row is open and which row it is. On each request it looks up that table. A row hit goes straight to the read or write command. A closed bank gets an activate first. An open bank holding a different row gets a precharge and then an activate. Because the precharge and activate steps are skipped whenever the table allows it, row hits reach the memory sooner.

Two request slots each run their own small sequencer. The slot that takes a request while the other is idle becomes the master and drives the memory. A request that arrives during that work waits in the other slot as slave. It starts only after the master's burst is complete, and at that point the two roles swap. Busy is high while both slots are occupied.

A programmable interval timer inserts refreshes. Any open banks are closed with a single precharge-all, the table is cleared, and then an auto-refresh follows. Refreshes keep running while the memory is held in power-down. The banks are addressed as chip select times four plus internal bank.

Top module: `sdram_cmd_sched`

## Requirements
- R1: A request to a closed bank issues ACT (code 1) with the row on `memAddr`. It then issues RD (code 2) or WR (code 3) with the column on `memAddr`, exactly `cfgTrcd` cycles after the ACT.
- R2: A request whose bank is open on the same row issues RD or WR directly, with no ACT or PRE before it.
- R3: A request whose bank is open on another row issues PRE (code 4). ACT follows exactly `cfgTrp` cycles later, and RD/WR follows `cfgTrcd` cycles after the ACT.
- R4: A request is taken in any cycle where `reqValid` is high and `busy` is low. `busy` is high exactly while both slots hold a request. A request presented while `busy` is high is dropped and produces no memory command.
- R5: A queued second request issues its first memory command exactly `cfgCas + cfgBurst` cycles after the first request's RD/WR. Requests are served in arrival order, and only one command is issued per cycle.
- R6: Every `cfgRefInt` cycles a refresh takes place. If any bank is open, PREALL (code 5) is issued, and REF (code 6) follows `cfgTrp` cycles later. If no bank is open, REF is issued alone. After a refresh every bank counts as closed, so the next access needs ACT.
- R7: Banks are indexed as chip select times four plus internal bank, and each bank's open row is tracked on its own.
- R8: A refresh that falls due while a request's sequence has started waits until that request's burst ends. The PREALL then comes `cfgCas + cfgBurst` cycles after the RD/WR.
- R9: `memCke` is low while `pwrDown` is high and no refresh is due or running. Refreshes still happen in power-down, and `memCke` is high whenever PREALL or REF is issued.
- R10: During and right after reset, `memCmd` is NOP (code 0), `busy` is low and `memCke` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBank | input | BANK_W | Bank index (chip select * 4 + internal bank) |
| reqRow | input | ROW_W | Row address |
| reqCol | input | COL_W | Column address |
| busy | output | 1 | Both slots occupied; requests are not taken |
| cfgTrcd | input | CNT_W | Activate-to-access cycles |
| cfgTrp | input | CNT_W | Precharge-to-activate cycles |
| cfgCas | input | CNT_W | CAS latency cycles |
| cfgBurst | input | CNT_W | Burst cycles |
| cfgTrfc | input | CNT_W | Refresh recovery cycles |
| cfgRefInt | input | REF_W | Refresh interval in cycles |
| pwrDown | input | 1 | Hold the memory in power-down |
| memCmd | output | 3 | Memory command code |
| memBank | output | BANK_W | Target bank of the command |
| memAddr | output | ROW_W | Row for ACT, column for RD/WR, zero otherwise |
| memCke | output | 1 | Clock enable to the memory |

## Verification
The assertions rely on several assumptions about the inputs:
- Every timing field is at least 2, and `cfgRefInt` is at least 2.
- `reqBank` stays below the bank count.
- The configuration does not change while a sequence is running.
- No request arrives during power-down.

The stimulus holds the configuration constant for the whole run and uses only in-range banks. It asserts `pwrDown` only while both slots are idle. It drives a request while `busy` is high once, deliberately, to exercise the drop rule. The deferred-refresh case is placed by timing a request from the observed cycle of the previous refresh, so that the next expiry falls between its ACT and its RD.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_ACT    = 3'd1,
    CMD_RD     = 3'd2,
    CMD_WR     = 3'd3,
    CMD_PRE    = 3'd4,
    CMD_PREALL = 3'd5,
    CMD_REF    = 3'd6
  } memCmd_e;

  // strobes from control to the open-row table
  typedef struct packed {
    logic act;
    logic pre;
    logic clrAll;
  } tblStrobe_s;

  localparam int BANKS_PER_CS = 4;

endpackage

// File: rtl/sched_bank_table.sv
module sched_bank_table
  import sched_pkg::*;
#(
  parameter int NB     = 8,
  parameter int BANK_W = 3,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  tblStrobe_s        strobe,
  input  logic [BANK_W-1:0] opBank,
  input  logic [ROW_W-1:0]  opRow,
  output logic              lookOpen,
  output logic              lookHit,
  output logic              anyOpen
);

  logic [NB-1:0]    openFlag;
  logic [ROW_W-1:0] openRow [NB];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openFlag <= '0;
      for (int i = 0; i < NB; i++) openRow[i] <= '0;
    end else if (strobe.clrAll) begin
      openFlag <= '0;
    end else begin
      if (strobe.act) begin
        openFlag[opBank] <= 1'b1;
        openRow[opBank]  <= opRow;
      end
      if (strobe.pre) openFlag[opBank] <= 1'b0;
    end
  end

  assign lookOpen = openFlag[opBank];
  assign lookHit  = (openRow[opBank] == opRow);
  assign anyOpen  = |openFlag;

  // an activate must only ever target a bank the table holds closed
  assert_act_closed_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.act |-> !openFlag[opBank]);

  // a precharge from a request only closes an open bank on another row
  assert_pre_miss_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pre |-> (openFlag[opBank] && (openRow[opBank] != opRow)));

  // after a precharge-all no bank may remain open
  assert_clear_all_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrAll |=> !anyOpen);

endmodule

// File: rtl/sched_slot.sv
module sched_slot
  import sched_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              inWrite,
  input  logic [BANK_W-1:0] inBank,
  input  logic [ROW_W-1:0]  inRow,
  input  logic [COL_W-1:0]  inCol,
  input  logic              grant,
  input  logic              lookOpen,
  input  logic              lookHit,
  input  logic [CNT_W-1:0]  cfgTrcd,
  input  logic [CNT_W-1:0]  cfgTrp,
  input  logic [CNT_W-1:0]  cfgCas,
  input  logic [CNT_W-1:0]  cfgBurst,
  output memCmd_e           issCmd,
  output logic              idle,
  output logic              started,
  output logic              done,
  output logic [BANK_W-1:0] curBank,
  output logic [ROW_W-1:0]  curRow,
  output logic [COL_W-1:0]  curCol
);

  localparam int CW = CNT_W + 1;

  typedef enum logic [1:0] {SL_IDLE, SL_PEND, SL_WAIT, SL_BURST} slotState_e;

  slotState_e    state;
  logic [CW-1:0] cnt;
  logic          isWrite;

  function automatic logic [CW-1:0] minus2(input logic [CW-1:0] v);
    return (v >= CW'(2)) ? v - CW'(2) : '0;
  endfunction

  // decide from the open-row table which command the pending request needs
  always_comb begin
    issCmd = CMD_NOP;
    if (state == SL_PEND && grant) begin
      if (lookOpen && lookHit) issCmd = isWrite ? CMD_WR : CMD_RD;
      else if (lookOpen)       issCmd = CMD_PRE;
      else                     issCmd = CMD_ACT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= SL_IDLE;
      cnt     <= '0;
      started <= 1'b0;
      isWrite <= 1'b0;
      curBank <= '0;
      curRow  <= '0;
      curCol  <= '0;
    end else begin
      case (state)
        SL_IDLE: if (load) begin
          state   <= SL_PEND;
          isWrite <= inWrite;
          curBank <= inBank;
          curRow  <= inRow;
          curCol  <= inCol;
          started <= 1'b0;
        end
        SL_PEND: if (issCmd != CMD_NOP) begin
          started <= 1'b1;
          case (issCmd)
            CMD_RD, CMD_WR: begin
              cnt   <= minus2(CW'(cfgCas) + CW'(cfgBurst));
              state <= SL_BURST;
            end
            CMD_PRE: begin
              cnt   <= minus2(CW'(cfgTrp));
              state <= SL_WAIT;
            end
            default: begin
              cnt   <= minus2(CW'(cfgTrcd));
              state <= SL_WAIT;
            end
          endcase
        end
        SL_WAIT: begin
          if (cnt == '0) state <= SL_PEND;
          else           cnt   <= cnt - 1'b1;
        end
        default: begin
          if (cnt == '0) begin
            state   <= SL_IDLE;
            started <= 1'b0;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign idle = (state == SL_IDLE);
  assign done = (state == SL_BURST) && (cnt == '0);

  // the cycle after an activate is always a wait cycle for this slot
  assert_act_gap_R1: assert property (@(posedge clk) disable iff (!rstN)
    (issCmd == CMD_ACT) |=> (issCmd == CMD_NOP));

  // a slot without the master grant never drives a command
  assert_slave_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    !grant |-> (issCmd == CMD_NOP));

endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int BANK_W = 3,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int CNT_W  = 4,
  parameter int REF_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic              busy,
  input  logic [CNT_W-1:0]  cfgTrcd,
  input  logic [CNT_W-1:0]  cfgTrp,
  input  logic [CNT_W-1:0]  cfgCas,
  input  logic [CNT_W-1:0]  cfgBurst,
  input  logic [CNT_W-1:0]  cfgTrfc,
  input  logic [REF_W-1:0]  cfgRefInt,
  input  logic              pwrDown,
  input  logic              lookOpen,
  input  logic              lookHit,
  input  logic              anyOpen,
  output tblStrobe_s        strobe,
  output logic [BANK_W-1:0] opBank,
  output logic [ROW_W-1:0]  opRow,
  output memCmd_e           memCmd,
  output logic [BANK_W-1:0] memBank,
  output logic [ROW_W-1:0]  memAddr,
  output logic              memCke
);

  localparam int NSLOT = 2;
  localparam int CW    = CNT_W + 1;

  typedef enum logic [1:0] {RF_IDLE, RF_PWAIT, RF_REF, RF_RWAIT} refState_e;

  memCmd_e           slotCmd  [NSLOT];
  logic [BANK_W-1:0] slotBank [NSLOT];
  logic [ROW_W-1:0]  slotRow  [NSLOT];
  logic [COL_W-1:0]  slotCol  [NSLOT];
  logic [NSLOT-1:0]  slotIdle, slotStarted, slotDone, slotLoad, slotGrant;

  logic       masterSel, tgtSlot, accept, masterStarted;
  memCmd_e    mCmd, refIss;
  refState_e  refState;
  logic       refPend, refStart, expire;
  logic [REF_W-1:0] refCnt;
  logic [CW-1:0]    waitCnt;

  function automatic logic [CW-1:0] minus2(input logic [CNT_W-1:0] v);
    return (CW'(v) >= CW'(2)) ? CW'(v) - CW'(2) : '0;
  endfunction

  // ---------------- request slots ----------------
  assign busy          = &(~slotIdle);
  assign accept        = reqValid && !busy;
  assign tgtSlot       = slotIdle[masterSel] ? masterSel : ~masterSel;
  assign masterStarted = slotStarted[masterSel];

  for (genvar g = 0; g < NSLOT; g++) begin : gSlot
    assign slotLoad[g]  = accept && (tgtSlot == 1'(g));
    assign slotGrant[g] = (masterSel == 1'(g)) && (refState == RF_IDLE) &&
                          (!refPend || slotStarted[g]);
    sched_slot #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) i_slot (
      .clk(clk), .rstN(rstN), .load(slotLoad[g]), .inWrite(reqWrite),
      .inBank(reqBank), .inRow(reqRow), .inCol(reqCol), .grant(slotGrant[g]),
      .lookOpen(lookOpen), .lookHit(lookHit), .cfgTrcd(cfgTrcd), .cfgTrp(cfgTrp),
      .cfgCas(cfgCas), .cfgBurst(cfgBurst), .issCmd(slotCmd[g]), .idle(slotIdle[g]),
      .started(slotStarted[g]), .done(slotDone[g]), .curBank(slotBank[g]),
      .curRow(slotRow[g]), .curCol(slotCol[g])
    );
  end

  // master token passes to the other slot when the master's burst ends
  always_ff @(posedge clk) begin
    if (!rstN)                    masterSel <= 1'b0;
    else if (slotDone[masterSel]) masterSel <= ~masterSel;
  end

  assign mCmd   = slotCmd[masterSel];
  assign opBank = slotBank[masterSel];
  assign opRow  = slotRow[masterSel];

  // ---------------- refresh engine ----------------
  assign expire   = (refCnt >= cfgRefInt - 1'b1);
  assign refStart = (refState == RF_IDLE) && refPend && !masterStarted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt  <= '0;
      refPend <= 1'b0;
    end else begin
      refCnt  <= expire ? '0 : refCnt + 1'b1;
      if (expire)        refPend <= 1'b1;
      else if (refStart) refPend <= 1'b0;
    end
  end

  always_comb begin
    refIss = CMD_NOP;
    if (refStart)                refIss = anyOpen ? CMD_PREALL : CMD_REF;
    else if (refState == RF_REF) refIss = CMD_REF;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refState <= RF_IDLE;
      waitCnt  <= '0;
    end else begin
      case (refState)
        RF_IDLE: if (refStart) begin
          if (anyOpen) begin
            refState <= RF_PWAIT;
            waitCnt  <= minus2(cfgTrp);
          end else begin
            refState <= RF_RWAIT;
            waitCnt  <= minus2(cfgTrfc);
          end
        end
        RF_PWAIT: begin
          if (waitCnt == '0) refState <= RF_REF;
          else               waitCnt  <= waitCnt - 1'b1;
        end
        RF_REF: begin
          refState <= RF_RWAIT;
          waitCnt  <= minus2(cfgTrfc);
        end
        default: begin
          if (waitCnt == '0) refState <= RF_IDLE;
          else               waitCnt  <= waitCnt - 1'b1;
        end
      endcase
    end
  end

  // ---------------- command output and table strobes ----------------
  always_comb begin
    memCmd  = CMD_NOP;
    memBank = '0;
    memAddr = '0;
    if (refIss != CMD_NOP) begin
      memCmd = refIss;
    end else if (mCmd != CMD_NOP) begin
      memCmd  = mCmd;
      memBank = opBank;
      if (mCmd == CMD_ACT)                         memAddr = opRow;
      else if (mCmd == CMD_RD || mCmd == CMD_WR)   memAddr = ROW_W'(slotCol[masterSel]);
    end
  end

  assign strobe.act    = (mCmd == CMD_ACT);
  assign strobe.pre    = (mCmd == CMD_PRE);
  assign strobe.clrAll = (refIss == CMD_PREALL);

  assign memCke = !pwrDown || refPend || (refState != RF_IDLE);

  // at most one source drives a command in any cycle
  assert_one_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({slotCmd[0] != CMD_NOP, slotCmd[1] != CMD_NOP, refIss != CMD_NOP}));

  // refresh commands never interrupt a started request
  assert_ref_defer_R8: assert property (@(posedge clk) disable iff (!rstN)
    (refIss != CMD_NOP) |-> !(|slotStarted));

  // busy only rises after a request was taken
  assert_busy_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(reqValid));

  // clock enable is up whenever a refresh command goes out
  assert_cke_ref_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memCmd == CMD_PREALL || memCmd == CMD_REF) |-> memCke);

endmodule

// File: rtl/sdram_cmd_sched.sv
module sdram_cmd_sched
  import sched_pkg::*;
#(
  parameter int NUM_CS = 2,
  parameter int ROW_W  = 13,
  parameter int COL_W  = 10,
  parameter int CNT_W  = 4,
  parameter int REF_W  = 16,
  localparam int NB     = NUM_CS * BANKS_PER_CS,
  localparam int BANK_W = $clog2(NB)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic              busy,
  input  logic [CNT_W-1:0]  cfgTrcd,
  input  logic [CNT_W-1:0]  cfgTrp,
  input  logic [CNT_W-1:0]  cfgCas,
  input  logic [CNT_W-1:0]  cfgBurst,
  input  logic [CNT_W-1:0]  cfgTrfc,
  input  logic [REF_W-1:0]  cfgRefInt,
  input  logic              pwrDown,
  output logic [2:0]        memCmd,
  output logic [BANK_W-1:0] memBank,
  output logic [ROW_W-1:0]  memAddr,
  output logic              memCke
);

  tblStrobe_s        strobe;
  logic [BANK_W-1:0] opBank;
  logic [ROW_W-1:0]  opRow;
  logic              lookOpen, lookHit, anyOpen;
  memCmd_e           cmdEnum;

  sched_ctrl #(.BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W), .REF_W(REF_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .busy(busy), .cfgTrcd(cfgTrcd), .cfgTrp(cfgTrp),
    .cfgCas(cfgCas), .cfgBurst(cfgBurst), .cfgTrfc(cfgTrfc), .cfgRefInt(cfgRefInt),
    .pwrDown(pwrDown), .lookOpen(lookOpen), .lookHit(lookHit), .anyOpen(anyOpen),
    .strobe(strobe), .opBank(opBank), .opRow(opRow), .memCmd(cmdEnum),
    .memBank(memBank), .memAddr(memAddr), .memCke(memCke)
  );

  sched_bank_table #(.NB(NB), .BANK_W(BANK_W), .ROW_W(ROW_W)) i_table (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opBank(opBank), .opRow(opRow),
    .lookOpen(lookOpen), .lookHit(lookHit), .anyOpen(anyOpen)
  );

  assign memCmd = cmdEnum;

endmodule

// File: tb/test_sdram_cmd_sched.sv
`timescale 1ns/1ps
module test_sdram_cmd_sched;

  localparam int REF_N = 3000;
  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3,
                         PRE = 3'd4, PREALL = 3'd5, REFC = 3'd6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [2:0]  reqBank = '0;
  logic [12:0] reqRow = '0;
  logic [9:0]  reqCol = '0;
  logic        busy, pwrDown = 1'b0, memCke;
  logic [2:0]  memCmd, memBank;
  logic [12:0] memAddr;

  int checks = 0, errors = 0, cyc = 0, lastCyc = 0, lastPreAll = 0, baseP = 0;

  typedef struct {
    logic [2:0]  cmd;
    logic [2:0]  bank;
    logic [12:0] addr;
    int          gap;
    string       tag;
  } exp_t;
  exp_t expQ[$];
  exp_t e;

  always #2 clk = ~clk;

  sdram_cmd_sched i_sdram_cmd_sched (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqBank(reqBank),
    .reqRow(reqRow), .reqCol(reqCol), .busy(busy), .cfgTrcd(4'd3), .cfgTrp(4'd2),
    .cfgCas(4'd3), .cfgBurst(4'd2), .cfgTrfc(4'd6), .cfgRefInt(16'(REF_N)),
    .pwrDown(pwrDown), .memCmd(memCmd), .memBank(memBank), .memAddr(memAddr), .memCke(memCke)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input logic [2:0] c, input logic [2:0] b, input int a, input int g, input string t);
    exp_t x;
    x.cmd = c; x.bank = b; x.addr = 13'(a); x.gap = g; x.tag = t;
    expQ.push_back(x);
  endtask

  // called just after a falling edge; request taken at the next rising edge
  task automatic drive(input logic w, input logic [2:0] b, input int r, input int c);
    reqValid = 1'b1; reqWrite = w; reqBank = b; reqRow = 13'(r); reqCol = 10'(c);
    @(negedge clk); #1;
    reqValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic waitUntil(input int target);
    while (cyc < target) begin
      @(negedge clk); #1;
    end
  endtask

  // monitor: pop expected commands and compare code, bank, address and spacing
  always @(negedge clk) begin
    cyc++;
    if (rstN && memCmd != NOP) begin
      if (memCmd == PREALL || memCmd == REFC) begin
        check(memCke == 1'b1, "R9 cke at refresh", int'(memCke), 1);
        if (memCmd == PREALL) lastPreAll = cyc;
      end
      if (expQ.size() == 0) begin
        check(1'b0, "R4 unexpected command", int'(memCmd), 0);
      end else begin
        e = expQ.pop_front();
        check(memCmd == e.cmd, {e.tag, " cmd"}, int'(memCmd), int'(e.cmd));
        check(memBank == e.bank && memAddr == e.addr, {e.tag, " bank/addr"},
              int'({memBank, memAddr}), int'({e.bank, e.addr}));
        if (e.gap >= 0) check(cyc - lastCyc == e.gap, {e.tag, " spacing"}, cyc - lastCyc, e.gap);
      end
      lastCyc = cyc;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    check(memCmd == NOP, "R10 cmd in reset", int'(memCmd), 0);
    check(busy == 1'b0, "R10 busy in reset", int'(busy), 0);
    check(memCke == 1'b1, "R10 cke in reset", int'(memCke), 1);
    rstN = 1'b1;
    idle(2);
    check(memCmd == NOP && busy == 1'b0, "R10 after reset", int'({busy, memCmd}), 0);

    // R1: closed bank
    push(ACT, 3'd0, 5, -1, "R1"); push(RD, 3'd0, 7, 3, "R1");
    drive(1'b0, 3'd0, 5, 7);
    idle(30);

    // R2: row hit
    push(WR, 3'd0, 9, -1, "R2");
    drive(1'b1, 3'd0, 5, 9);
    idle(30);

    // R3: row miss
    push(PRE, 3'd0, 0, -1, "R3"); push(ACT, 3'd0, 6, 2, "R3"); push(RD, 3'd0, 3, 3, "R3");
    drive(1'b0, 3'd0, 6, 3);
    idle(30);

    // R4, R5, R7: two queued requests on different chip selects, third one dropped
    push(ACT, 3'd2, 1, -1, "R7"); push(RD, 3'd2, 1, 3, "R5");
    push(ACT, 3'd5, 3, 5, "R5");  push(WR, 3'd5, 4, 3, "R7");
    reqValid = 1'b1; reqWrite = 1'b0; reqBank = 3'd2; reqRow = 13'd1; reqCol = 10'd1;
    @(negedge clk); #1;
    reqWrite = 1'b1; reqBank = 3'd5; reqRow = 13'd3; reqCol = 10'd4;
    @(negedge clk); #1;
    check(busy == 1'b1, "R4 busy with two slots", int'(busy), 1);
    reqWrite = 1'b0; reqBank = 3'd7; reqRow = 13'd2; reqCol = 10'd2;
    @(negedge clk); #1;
    reqValid = 1'b0;
    idle(40);
    check(busy == 1'b0, "R4 busy released", int'(busy), 0);
    check(expQ.size() == 0, "R4 queued work drained", expQ.size(), 0);

    // R6: periodic refresh closes open banks
    push(PREALL, 3'd0, 0, -1, "R6"); push(REFC, 3'd0, 0, 2, "R6");
    while (expQ.size() != 0) idle(1);
    baseP = lastPreAll;
    idle(20);
    push(ACT, 3'd0, 6, -1, "R6"); push(RD, 3'd0, 3, 3, "R6");
    drive(1'b0, 3'd0, 6, 3);
    idle(30);

    // R8: next expiry lands between ACT and RD; refresh must wait for the burst
    waitUntil(baseP + REF_N - 3);
    push(ACT, 3'd1, 9, -1, "R8"); push(RD, 3'd1, 2, 3, "R8");
    push(PREALL, 3'd0, 0, 5, "R8"); push(REFC, 3'd0, 0, 2, "R8");
    drive(1'b0, 3'd1, 9, 2);
    waitUntil(baseP + REF_N + 30);
    check(expQ.size() == 0, "R8 deferred refresh seen", expQ.size(), 0);

    // R9: power-down, refresh still runs with clock enable raised
    pwrDown = 1'b1;
    idle(1);
    check(memCke == 1'b0, "R9 cke low in power-down", int'(memCke), 0);
    push(REFC, 3'd0, 0, -1, "R9");
    waitUntil(baseP + 2 * REF_N + 10);
    check(expQ.size() == 0, "R9 refresh during power-down", expQ.size(), 0);
    pwrDown = 1'b0;
    idle(1);
    check(memCke == 1'b1, "R9 cke high after wake", int'(memCke), 1);

    idle(20);
    check(expQ.size() == 0, "R5 all expected commands seen", expQ.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule